// File: doc/BRIEF.md
# Keyboard Controller Command Sequencer

This block carries out one host command against a byte-wide keyboard-controller register set. That register set has a control/status register and a data register. A 16-bit command word says three things: which opcode goes to the control register, how many argument bytes follow it into the data register, and how many reply bytes must be read back. Argument and reply bytes live in one small indexed buffer. The host fills the buffer before the command and reads it afterwards. Every register write waits until the controller's input buffer is free. Every reply read waits until the controller's output buffer holds a byte. Each wait is a bounded poll of the status register.

The block can also drain the controller. It reads and discards data bytes while the controller reports pending output, up to a fixed limit. It reports how many bytes it drained, and hitting the limit marks the controller as absent. A loopback opcode gets extra treatment. Each of its replies must be tagged as coming from the auxiliary channel. A configuration input can refuse the loopback opcode outright. One transaction runs at a time, and each one ends in a single-cycle done pulse with a two-bit result.

Top module: `kbc_cmd_seq`

## Requirements
- R1: Command word bits [7:0] are the opcode, bits [15:12] the argument count, bits [11:8] the reply count. The opcode is written first, with `reg_sel`=1 (control register). Arguments follow with `reg_sel`=0 (data register), taken from buffer slots 0, 1, 2 and so on in rising order. A command with both counts zero performs only the opcode write.
- R2: Every register write happens in the cycle right after a status read (`reg_rd` with `reg_sel`=1) that returned bit 1, input-buffer-full, clear.
- R3: Every data-register read happens in the cycle right after a status read that returned bit 0, output-buffer-full, set. Reply byte k is stored in buffer slot k and replaces the argument held there. Slots at or above the reply count keep their contents.
- R4: Each wait issues at most POLL_LIMIT status reads. Consecutive reads within one wait are separated by exactly POLL_GAP cycles without register access. If a wait is still not satisfied at its last read, the transaction ends with result 2'b01 (timeout) and makes no further register access. A wait satisfied at its last read succeeds.
- R5: For opcode LOOP_OP, the status read that precedes each reply must have bit 5 (auxiliary data) set. If it does not, the transaction ends with result 2'b10 and the data byte is not read.
- R6: When `loop_en` is 0, a start carrying opcode LOOP_OP ends with result 2'b11 and a done pulse one cycle after the start, with no register access.
- R7: A flush repeats two steps while status bit 0 is set: read the status, then read and discard one data byte. It ends with result 2'b00 when bit 0 reads clear. It ends with result 2'b01 when FLUSH_LIMIT bytes have been drained. `flush_count` gives the number of bytes drained.
- R8: `done` is high for exactly one cycle per transaction, and `result` holds its code. `busy` stays high from an accepted start or flush until the done cycle. Starts, flushes and host buffer writes that arrive while busy are ignored.
- R9: After reset, `busy`, `done`, `reg_rd` and `reg_wr` are low, and every buffer slot reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a command transaction (taken when idle) |
| cmd_word | input | 16 | Opcode and byte counts |
| flush_req | input | 1 | Begin a flush (taken when idle and no start) |
| loop_en | input | 1 | 0 refuses the loopback opcode |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| result | output | 2 | 00 ok, 01 timeout/limit, 10 aux error, 11 refused |
| flush_count | output | FCW | Bytes drained by the last flush |
| buf_we | input | 1 | Host write to the byte buffer |
| buf_addr | input | 4 | Host buffer slot |
| buf_wdata | input | 8 | Host write data |
| buf_rdata | output | 8 | Buffer slot contents at `buf_addr` |
| reg_rd | output | 1 | Register read strobe |
| reg_wr | output | 1 | Register write strobe |
| reg_sel | output | 1 | 1 control/status register, 0 data register |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data, valid in the strobe cycle |

## Verification
The bench builds the sequencer with POLL_GAP=3, POLL_LIMIT=4 and FLUSH_LIMIT=5, so a timed-out wait costs only about a dozen cycles. With these values the bench can stall the controller model for exactly the last permitted poll and for one poll more. It can also measure the spacing between status reads cycle by cycle. A queue of seven pending bytes reaches the flush limit and leaves a remainder for a second flush.

// File: rtl/kbc_pkg.sv
// Shared types and status-register bit positions for the keyboard-controller
// command sequencer. Bit positions follow the controller's status layout.
package kbc_pkg;

    typedef enum logic [1:0] {
        KS_OK      = 2'b00,
        KS_TIMEOUT = 2'b01,
        KS_AUXERR  = 2'b10,
        KS_REJECT  = 2'b11
    } kbc_res_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL,
        ST_GAP,
        ST_ACT,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_OPC,
        PH_ARG,
        PH_RSP,
        PH_FLUSH
    } seq_phase_e;

    localparam int STB_OBF = 0;   // controller holds a byte for the host
    localparam int STB_IBF = 1;   // controller has not consumed the last write
    localparam int STB_AUX = 5;   // pending byte came from the auxiliary channel

    localparam logic SEL_DATA = 1'b0;
    localparam logic SEL_CTRL = 1'b1;

    localparam int BUF_DEPTH = 16;
    localparam int BUF_AW    = $clog2(BUF_DEPTH);

endpackage

// File: rtl/kbc_poll_timer.sv
// Poll pacing for one wait: a gap counter that spaces status reads apart and
// an attempt counter that bounds how many reads one wait may issue.
// Assumes POLL_GAP >= 1 and POLL_LIMIT >= 2; miss is never raised on the last try.
module kbc_poll_timer #(
    parameter int POLL_GAP   = 5000,
    parameter int POLL_LIMIT = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic att_clr,
    input  logic miss,
    output logic gap_expire,
    output logic last_try
);
    localparam int GW = $clog2(POLL_GAP + 1);
    localparam int LW = $clog2(POLL_LIMIT);

    logic [GW-1:0] gap_cnt;
    logic [LW-1:0] att_cnt;

    // Gap counter: loaded on a miss, counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= '0;
        end else if (miss) begin
            gap_cnt <= GW'(POLL_GAP);
        end else if (gap_cnt != '0) begin
            gap_cnt <= gap_cnt - 1'b1;
        end
    end

    // Attempt counter: cleared between waits, bumped on each miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            att_cnt <= '0;
        end else if (att_clr) begin
            att_cnt <= '0;
        end else if (miss) begin
            att_cnt <= att_cnt + 1'b1;
        end
    end

    assign gap_expire = (gap_cnt == GW'(1));
    assign last_try   = (att_cnt == LW'(POLL_LIMIT - 1));

    // R4: the attempt count never passes the final permitted read
    a_r4_attempt_cap: assert property (@(posedge clk) disable iff (!rst_n)
        att_cnt <= LW'(POLL_LIMIT - 1));

    // R4: a gap always lasts the full spacing before expiring
    a_r4_gap_full: assert property (@(posedge clk) disable iff (!rst_n)
        miss |=> (gap_cnt == GW'(POLL_GAP)));

endmodule

// File: rtl/kbc_xfer_buf.sv
// Shared argument/reply byte buffer. The host writes it while the sequencer
// is idle; the sequencer writes reply bytes while busy. Both read freely.
module kbc_xfer_buf
    import kbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock,
    input  logic              host_we,
    input  logic [BUF_AW-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              seq_we,
    input  logic [BUF_AW-1:0] seq_addr,
    input  logic [7:0]        seq_wdata,
    output logic [7:0]        seq_rdata
);
    logic [BUF_DEPTH-1:0][7:0] slot;

    // One register per slot; the sequencer owns writes while locked.
    for (genvar g = 0; g < BUF_DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[g] <= '0;
            end else if (lock) begin
                if (seq_we && seq_addr == BUF_AW'(g)) slot[g] <= seq_wdata;
            end else if (host_we && host_addr == BUF_AW'(g)) begin
                slot[g] <= host_wdata;
            end
        end
    end

    assign host_rdata = slot[host_addr];
    assign seq_rdata  = slot[seq_addr];

    // R8: while locked, only sequencer writes may change the buffer
    a_r8_buf_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !seq_we) |=> $stable(slot));

endmodule

// File: rtl/kbc_cmd_seq.sv
// Keyboard-controller command sequencer (top). Runs one command transaction:
// opcode write, argument writes, reply reads, each gated by a bounded status
// poll; or a flush that drains pending controller output. Assumes the
// controller returns read data combinationally in the strobe cycle.
module kbc_cmd_seq
    import kbc_pkg::*;
#(
    parameter int         POLL_GAP    = 5000,
    parameter int         POLL_LIMIT  = 10000,
    parameter int         FLUSH_LIMIT = 16,
    parameter logic [7:0] LOOP_OP     = 8'hD3,
    localparam int        FCW         = $clog2(FLUSH_LIMIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       cmd_word,
    input  logic              flush_req,
    input  logic              loop_en,
    output logic              busy,
    output logic              done,
    output logic [1:0]        result,
    output logic [FCW-1:0]    flush_count,
    input  logic              buf_we,
    input  logic [BUF_AW-1:0] buf_addr,
    input  logic [7:0]        buf_wdata,
    output logic [7:0]        buf_rdata,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic              reg_sel,
    output logic [7:0]        reg_wdata,
    input  logic [7:0]        reg_rdata
);
    seq_state_e        state;
    seq_phase_e        phase;
    kbc_res_e          res;
    logic [7:0]        opc;
    logic [3:0]        n_arg;
    logic [3:0]        n_rsp;
    logic [BUF_AW-1:0] idx;
    logic              is_loop;
    logic [FCW-1:0]    fcnt;

    logic       ready;
    logic       miss;
    logic       att_clr;
    logic       gap_expire;
    logic       last_try;
    logic       seq_we;
    logic [7:0] seq_rdata;

    // Register strobes come straight from the state and phase.
    always_comb begin
        reg_rd  = (state == ST_POLL) ||
                  (state == ST_ACT && (phase == PH_RSP || phase == PH_FLUSH));
        reg_wr  = (state == ST_ACT) && (phase == PH_OPC || phase == PH_ARG);
        reg_sel = (state == ST_POLL || phase == PH_OPC) ? SEL_CTRL : SEL_DATA;
        reg_wdata = (phase == PH_OPC) ? opc : seq_rdata;
    end

    // Readiness of the current wait, judged on the status byte.
    always_comb begin
        if (phase == PH_OPC || phase == PH_ARG) ready = !reg_rdata[STB_IBF];
        else                                    ready =  reg_rdata[STB_OBF];
    end

    assign miss    = (state == ST_POLL) && (phase != PH_FLUSH) && !ready && !last_try;
    assign att_clr = (state != ST_POLL) && (state != ST_GAP);
    assign seq_we  = (state == ST_ACT) && (phase == PH_RSP);

    // Transaction sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            phase   <= PH_OPC;
            res     <= KS_OK;
            opc     <= '0;
            n_arg   <= '0;
            n_rsp   <= '0;
            idx     <= '0;
            is_loop <= 1'b0;
            fcnt    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    idx <= '0;
                    if (start) begin
                        opc     <= cmd_word[7:0];
                        n_arg   <= cmd_word[15:12];
                        n_rsp   <= cmd_word[11:8];
                        is_loop <= (cmd_word[7:0] == LOOP_OP);
                        phase   <= PH_OPC;
                        if (cmd_word[7:0] == LOOP_OP && !loop_en) begin
                            res   <= KS_REJECT;
                            state <= ST_DONE;
                        end else begin
                            state <= ST_POLL;
                        end
                    end else if (flush_req) begin
                        phase <= PH_FLUSH;
                        fcnt  <= '0;
                        state <= ST_POLL;
                    end
                end
                ST_POLL: begin
                    if (phase == PH_FLUSH) begin
                        if (ready) begin
                            state <= ST_ACT;
                        end else begin
                            res   <= KS_OK;
                            state <= ST_DONE;
                        end
                    end else if (ready) begin
                        if (phase == PH_RSP && is_loop && !reg_rdata[STB_AUX]) begin
                            res   <= KS_AUXERR;
                            state <= ST_DONE;
                        end else begin
                            state <= ST_ACT;
                        end
                    end else if (last_try) begin
                        res   <= KS_TIMEOUT;
                        state <= ST_DONE;
                    end else begin
                        state <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (gap_expire) state <= ST_POLL;
                end
                ST_ACT: begin
                    unique case (phase)
                        PH_OPC: begin
                            idx <= '0;
                            if (n_arg != '0) begin
                                phase <= PH_ARG;
                                state <= ST_POLL;
                            end else if (n_rsp != '0) begin
                                phase <= PH_RSP;
                                state <= ST_POLL;
                            end else begin
                                res   <= KS_OK;
                                state <= ST_DONE;
                            end
                        end
                        PH_ARG: begin
                            if (idx == n_arg - 4'd1) begin
                                idx <= '0;
                                if (n_rsp != '0) begin
                                    phase <= PH_RSP;
                                    state <= ST_POLL;
                                end else begin
                                    res   <= KS_OK;
                                    state <= ST_DONE;
                                end
                            end else begin
                                idx   <= idx + 1'b1;
                                state <= ST_POLL;
                            end
                        end
                        PH_RSP: begin
                            if (idx == n_rsp - 4'd1) begin
                                res   <= KS_OK;
                                state <= ST_DONE;
                            end else begin
                                idx   <= idx + 1'b1;
                                state <= ST_POLL;
                            end
                        end
                        default: begin
                            fcnt <= fcnt + 1'b1;
                            if (fcnt + 1'b1 == FCW'(FLUSH_LIMIT)) begin
                                res   <= KS_TIMEOUT;
                                state <= ST_DONE;
                            end else begin
                                state <= ST_POLL;
                            end
                        end
                    endcase
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    assign busy        = (state != ST_IDLE);
    assign done        = (state == ST_DONE);
    assign result      = res;
    assign flush_count = fcnt;

    kbc_poll_timer #(
        .POLL_GAP   (POLL_GAP),
        .POLL_LIMIT (POLL_LIMIT)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .att_clr    (att_clr),
        .miss       (miss),
        .gap_expire (gap_expire),
        .last_try   (last_try)
    );

    kbc_xfer_buf u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock       (busy),
        .host_we    (buf_we),
        .host_addr  (buf_addr),
        .host_wdata (buf_wdata),
        .host_rdata (buf_rdata),
        .seq_we     (seq_we),
        .seq_addr   (idx),
        .seq_wdata  (reg_rdata),
        .seq_rdata  (seq_rdata)
    );

    // R2: a write only follows a status read showing the input buffer free
    a_r2_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> $past(reg_rd && reg_sel == SEL_CTRL && !reg_rdata[STB_IBF]));

    // R3: a data read only follows a status read showing a pending byte
    a_r3_read_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel == SEL_DATA) |-> $past(reg_rd && reg_sel == SEL_CTRL && reg_rdata[STB_OBF]));

    // R5: an aux error is reported only after a status lacking the aux tag
    a_r5_aux_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == KS_AUXERR) |-> $past(reg_rd && reg_sel == SEL_CTRL && !reg_rdata[STB_AUX]));

    // R6: a refusal comes one cycle after an accepted start
    a_r6_reject_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == KS_REJECT) |-> $past(start && !busy));

    // R8: done never lasts two cycles
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: no register traffic once idle
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!reg_rd && !reg_wr));

endmodule

// File: tb/kbc_cmd_seq_bench.sv
module kbc_cmd_seq_bench;
    localparam int         GAP   = 3;
    localparam int         LIM   = 4;
    localparam int         FLIM  = 5;
    localparam logic [7:0] LOOP  = 8'hD3;
    localparam int         FCW   = $clog2(FLIM + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [15:0] cmd_word = '0;
    logic flush_req = 1'b0;
    logic loop_en = 1'b1;
    logic busy, done;
    logic [1:0] result;
    logic [FCW-1:0] flush_count;
    logic buf_we = 1'b0;
    logic [3:0] buf_addr = '0;
    logic [7:0] buf_wdata = '0;
    logic [7:0] buf_rdata;
    logic reg_rd, reg_wr, reg_sel;
    logic [7:0] reg_wdata, reg_rdata;

    always #5 clk = ~clk;

    kbc_cmd_seq #(
        .POLL_GAP(GAP), .POLL_LIMIT(LIM), .FLUSH_LIMIT(FLIM), .LOOP_OP(LOOP)
    ) u_kbc_cmd_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_word(cmd_word),
        .flush_req(flush_req), .loop_en(loop_en), .busy(busy), .done(done),
        .result(result), .flush_count(flush_count), .buf_we(buf_we),
        .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // Controller model: pending-byte queue plus a stall window on status reads.
    logic [7:0] q_dat [0:63];
    logic       q_aux [0:63];
    int q_head = 0, q_tail = 0;
    int stall_until = 0;
    int n_stat = 0, n_drd = 0, n_wr = 0, cyc = 0;
    logic [7:0] wr_d [0:255];
    logic       wr_s [0:255];
    int         st_t [0:255];
    logic       stalled, pending;
    logic [7:0] st_byte;

    assign stalled   = (n_stat < stall_until);
    assign pending   = (q_head != q_tail);
    assign st_byte   = {2'b00, q_aux[q_head & 63], 3'b000, stalled, pending && !stalled};
    assign reg_rdata = reg_sel ? st_byte : q_dat[q_head & 63];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && reg_rd && reg_sel) begin
            st_t[n_stat & 255] <= cyc;
            n_stat <= n_stat + 1;
        end
        if (rst_n && reg_rd && !reg_sel) begin
            q_head <= q_head + 1;
            n_drd  <= n_drd + 1;
        end
        if (rst_n && reg_wr) begin
            wr_d[n_wr & 255] <= reg_wdata;
            wr_s[n_wr & 255] <= reg_sel;
            n_wr <= n_wr + 1;
        end
    end

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic aux);
        q_dat[q_tail & 63] = d;
        q_aux[q_tail & 63] = aux;
        q_tail = q_tail + 1;
    endtask

    task automatic hwrite(input int a, input logic [7:0] d);
        @(negedge clk);
        buf_we = 1'b1; buf_addr = 4'(a); buf_wdata = d;
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    task automatic hread(input int a, output int d);
        buf_addr = 4'(a);
        #1;
        d = int'(buf_rdata);
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_cmd(input logic [15:0] w);
        @(negedge clk);
        start = 1'b1; cmd_word = w;
        @(negedge clk);
        start = 1'b0;
        wait_done();
    endtask

    task automatic run_flush();
        @(negedge clk);
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        wait_done();
    endtask

    task automatic t_reset();
        int d;
        chk("R9 busy", busy, 0);
        chk("R9 done", done, 0);
        chk("R9 strobes", {reg_rd, reg_wr}, 0);
        hread(7, d);
        chk("R9 slot7", d, 0);
    endtask

    task automatic t_full_cmd();
        int w0 = n_wr, r0 = n_drd, d;
        hwrite(0, 8'h11); hwrite(1, 8'h22); hwrite(2, 8'h33);
        push(8'hA1, 1'b0); push(8'hB2, 1'b0);
        run_cmd(16'h2247);
        chk("R8 result ok", result, 0);
        chk("R1 writes", n_wr - w0, 3);
        chk("R1 opcode", {wr_s[w0 & 255], wr_d[w0 & 255]}, 9'h147);
        chk("R1 arg0", {wr_s[(w0 + 1) & 255], wr_d[(w0 + 1) & 255]}, 9'h011);
        chk("R1 arg1", {wr_s[(w0 + 2) & 255], wr_d[(w0 + 2) & 255]}, 9'h022);
        chk("R3 reads", n_drd - r0, 2);
        @(negedge clk);
        hread(0, d); chk("R3 slot0", d, 8'hA1);
        hread(1, d); chk("R3 slot1", d, 8'hB2);
        hread(2, d); chk("R3 slot2 kept", d, 8'h33);
    endtask

    task automatic t_zero_cmd();
        int w0 = n_wr, r0 = n_drd;
        run_cmd(16'h00AA);
        chk("R1 zero result", result, 0);
        chk("R1 zero writes", n_wr - w0, 1);
        chk("R1 zero opcode", wr_d[w0 & 255], 8'hAA);
        chk("R1 zero reads", n_drd - r0, 0);
        @(negedge clk);
    endtask

    task automatic t_stall_last();
        int s0 = n_stat, w0 = n_wr;
        stall_until = n_stat + LIM - 1;
        run_cmd(16'h0060);
        chk("R4 last poll ok", result, 0);
        chk("R4 polls used", n_stat - s0, LIM);
        chk("R4 write after", n_wr - w0, 1);
        chk("R4 spacing", st_t[(s0 + 1) & 255] - st_t[s0 & 255], GAP + 1);
        chk("R4 spacing2", st_t[(s0 + 3) & 255] - st_t[(s0 + 2) & 255], GAP + 1);
        @(negedge clk);
    endtask

    task automatic t_timeout();
        int s0 = n_stat, w0 = n_wr;
        stall_until = n_stat + 100;
        run_cmd(16'h1061);
        chk("R4 timeout code", result, 1);
        chk("R4 timeout polls", n_stat - s0, LIM);
        chk("R4 no write", n_wr - w0, 0);
        repeat (5) @(negedge clk);
        chk("R4 quiet after", n_stat - s0, LIM);
        stall_until = 0;
        @(negedge clk);
    endtask

    task automatic t_loop_ok();
        int d;
        hwrite(0, 8'h5A);
        push(8'h5A, 1'b1);
        run_cmd({8'h11, LOOP});
        chk("R5 loop ok", result, 0);
        @(negedge clk);
        hread(0, d); chk("R5 loop echo", d, 8'h5A);
    endtask

    task automatic t_loop_aux_err();
        int r0 = n_drd;
        push(8'h5A, 1'b0);
        run_cmd({8'h11, LOOP});
        chk("R5 aux err code", result, 2);
        chk("R5 no data read", n_drd - r0, 0);
        @(negedge clk);
        run_flush();
        chk("R7 leftover count", flush_count, 1);
        chk("R7 leftover code", result, 0);
        @(negedge clk);
    endtask

    task automatic t_reject();
        int s0 = n_stat, w0 = n_wr;
        loop_en = 1'b0;
        @(negedge clk);
        start = 1'b1; cmd_word = {8'h11, LOOP};
        @(negedge clk);
        start = 1'b0;
        chk("R6 done next cycle", done, 1);
        chk("R6 reject code", result, 3);
        chk("R6 no access", (n_stat - s0) + (n_wr - w0), 0);
        loop_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_flush();
        for (int i = 0; i < 3; i++) push(8'(8'h40 + i), 1'b0);
        run_flush();
        chk("R7 flush count", flush_count, 3);
        chk("R7 flush code", result, 0);
        @(negedge clk);
        for (int i = 0; i < 7; i++) push(8'(8'h50 + i), 1'b0);
        run_flush();
        chk("R7 limit count", flush_count, FLIM);
        chk("R7 limit code", result, 1);
        @(negedge clk);
        run_flush();
        chk("R7 remainder", flush_count, 2);
        @(negedge clk);
    endtask

    task automatic t_busy_ignore();
        int w0 = n_wr, d;
        hwrite(4, 8'h44);
        stall_until = n_stat + 2;
        @(negedge clk);
        start = 1'b1; cmd_word = 16'h0070;
        @(negedge clk);
        start = 1'b0;
        chk("R8 busy", busy, 1);
        start = 1'b1; cmd_word = 16'h0071;
        buf_we = 1'b1; buf_addr = 4'd4; buf_wdata = 8'h99;
        @(negedge clk);
        start = 1'b0; buf_we = 1'b0;
        wait_done();
        @(negedge clk);
        chk("R8 done low after", done, 0);
        repeat (4) @(negedge clk);
        chk("R8 single txn", n_wr - w0, 1);
        chk("R8 opcode kept", wr_d[w0 & 255], 8'h70);
        hread(4, d); chk("R8 buf locked", d, 8'h44);
        stall_until = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_cmd();
        t_zero_cmd();
        t_stall_last();
        t_timeout();
        t_loop_ok();
        t_loop_aux_err();
        t_reject();
        t_flush();
        t_busy_ignore();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule